// File: doc/BRIEF.md
# Tagged Lookup-Table Execution Unit with Miss Fault

This block is an extra execution unit placed next to a processor register file. Each cycle it may be handed two register operands and an 11-bit function identifier. Its datapath is a grid of 4-input lookup tables, three levels deep and one slice per result bit. The grid holds one loaded function at a time, and a tag records that function's identifier. When the issued identifier equals the tag, the result goes back to the register file in the same cycle, as from any other single-cycle unit. When it differs, the unit signals a miss fault so that trap software can reload the tables and retry.

The operand path keeps nothing from one operation to the next. Only the configuration (truth tables and tag) is held, so a context switch never has to save the unit. Configuration is written one word per cycle through a write strobe, an address and a data word. Writing any truth table withdraws the tag, and writing the tag word makes the new function live.

Top module: `lut_exec_unit`

## Requirements
- R1: The function identifier `fid` is 11 bits wide. When `issue` is high, the tag is valid and `fid` equals the tag in all 11 bits, `res_valid` is 1 and `miss_fault` is 0 in that same cycle.
- R2: When `issue` is high and the tag is not valid, or `fid` differs from the tag in any bit, `miss_fault` is 1, `res_valid` is 0 and `result` is 0 in that cycle.
- R3: After reset no function is loaded, so every issued operation faults until a tag write completes.
- R4: A configuration write to a table address (0 to 95) marks the tag invalid from the next cycle. Every issue faults from then until the next tag write.
- R5: A configuration write to address 127 loads `cfg_wdata[10:0]` as the tag and makes it valid from the next cycle.
- R6: Table address L*32+i holds the 16-bit truth table for level L (0..2) of slice i. A table's output is bit {in3,in2,in1,in0} of its table. In the rules below, p=(i-1) mod 32 and n=(i+1) mod 32. Level 0 takes (in0..in3) = (a[i], b[i], a[p], b[p]). Level 1 takes (x0[i], x0[p], a[i], b[i]). Level 2 takes (x1[i], x1[p], x0[i], x1[n]), and its output is `result[i]` on a hit.
- R7: When `issue` is low, `res_valid`, `miss_fault` and `result` are all 0.
- R8: Configuration writes to addresses 96 to 126 change neither the tables nor the tag.
- R9: The result of a hit depends only on the current operands and configuration, and not on earlier operations.
- R10: A configuration write has no effect on an operation issued in the same cycle. That operation uses the configuration that was in place before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the tag valid flag |
| issue | input | 1 | Operation issued this cycle |
| fid | input | 11 | Requested function identifier |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| result | output | 32 | Result to the register file, zero unless a hit |
| res_valid | output | 1 | Hit: result is valid this cycle |
| miss_fault | output | 1 | Issued identifier not loaded: trap request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address (0..95 tables, 127 tag) |
| cfg_wdata | input | 16 | Truth table, or tag in bits 10:0 |

## Verification
The hardest cases to reach are the windows where the tag is invalid while valid-looking tables are present. These are a partial reload, and a write landing in the same cycle as an issue. Random identifiers would almost never hit a loaded tag. The stimulus therefore issues the loaded identifier in the middle of each reload, and again in the exact cycle of a table write. It also issues identifiers that differ from the tag in a single bit, walking through all eleven positions. Random operands then run against fully random tables and against a directed exclusive-or configuration.

// File: rtl/lut_exec_unit.sv
module lut_exec_unit #(
  parameter int W      = 32,
  parameter int FID_W  = 11,
  parameter int CFG_AW = 7,
  parameter int CFG_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [FID_W-1:0]  fid,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  output logic [W-1:0]      result,
  output logic              res_valid,
  output logic              miss_fault,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata
);
  localparam int LVL  = 3;
  localparam int NLUT = W * LVL;
  localparam logic [CFG_AW-1:0] NLUT_A  = CFG_AW'(NLUT);
  localparam logic [CFG_AW-1:0] TAG_ADR = '1;

  logic [15:0]      tt [NLUT];
  logic [FID_W-1:0] tag;
  logic             tag_ok;
  logic [W-1:0]     x0, x1, y;
  logic             hit;

  always_ff @(posedge clk)
    if (cfg_we && cfg_addr < NLUT_A) tt[cfg_addr] <= cfg_wdata[15:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tag_ok <= 1'b0;
      tag    <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == TAG_ADR) begin
        tag    <= cfg_wdata[FID_W-1:0];
        tag_ok <= 1'b1;
      end else if (cfg_addr < NLUT_A) begin
        tag_ok <= 1'b0;
      end
    end

  for (genvar i = 0; i < W; i++) begin : g_slice
    localparam int P = (i + W - 1) % W;
    localparam int N = (i + 1) % W;
    assign x0[i] = tt[i][{opb[P], opa[P], opb[i], opa[i]}];
    assign x1[i] = tt[W + i][{opb[i], opa[i], x0[P], x0[i]}];
    assign y[i]  = tt[2*W + i][{x1[N], x0[i], x1[P], x1[i]}];
  end

  assign hit        = tag_ok && (fid == tag);
  assign res_valid  = issue && hit;
  assign miss_fault = issue && !hit;
  assign result     = res_valid ? y : '0;
endmodule

// File: rtl/lut_exec_unit_chk.sv
module lut_exec_unit_chk #(
  parameter int W      = 32,
  parameter int FID_W  = 11,
  parameter int CFG_AW = 7,
  parameter int CFG_DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [FID_W-1:0]  fid,
  input logic [W-1:0]      result,
  input logic              res_valid,
  input logic              miss_fault,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata
);
  localparam logic [CFG_AW-1:0] NLUT_A  = CFG_AW'(W * 3);
  localparam logic [CFG_AW-1:0] TAG_ADR = '1;

  logic seen_tag;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_tag <= 1'b0;
    else if (cfg_we && cfg_addr == TAG_ADR) seen_tag <= 1'b1;

  // R2
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fault |-> (!res_valid && result == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> (!miss_fault && !res_valid && result == '0));

  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ($countones({miss_fault, res_valid}) == 1));

  // R3
  unloaded_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !seen_tag) |-> miss_fault);

  // R4
  table_wr_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr < NLUT_A) |=> (!issue || miss_fault));

  // R5
  tag_wr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == TAG_ADR) |=>
      (!issue || fid != $past(cfg_wdata[FID_W-1:0]) || res_valid));
endmodule

bind lut_exec_unit lut_exec_unit_chk #(
  .W(W), .FID_W(FID_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
) u_chk (.*);

// File: tb/tb_lut_exec_unit.sv
module tb_lut_exec_unit;
  localparam int W = 32;
  localparam int NLUT = 96;

  logic        clk = 0, rst_n = 0, issue = 0, cfg_we = 0;
  logic [10:0] fid = '0;
  logic [31:0] opa = '0, opb = '0, result;
  logic        res_valid, miss_fault;
  logic [6:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;

  lut_exec_unit dut (.*);

  always #5 clk = ~clk;

  logic [15:0] mdl [NLUT];
  logic [10:0] mtag = '0;
  bit          mvalid = 0;
  int          vecs = 0, bad = 0;

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] x0, x1, y;
    for (int i = 0; i < W; i++) x0[i] = mdl[i][{b[(i+W-1)%W], a[(i+W-1)%W], b[i], a[i]}];
    for (int i = 0; i < W; i++) x1[i] = mdl[W+i][{b[i], a[i], x0[(i+W-1)%W], x0[i]}];
    for (int i = 0; i < W; i++) y[i] = mdl[2*W+i][{x1[(i+1)%W], x0[i], x1[(i+W-1)%W], x1[i]}];
    return y;
  endfunction

  function automatic logic [33:0] expect_out(input logic [10:0] f, input logic [31:0] a, input logic [31:0] b);
    bit h = mvalid && (f == mtag);
    return {h, !h, h ? model(a, b) : 32'h0};
  endfunction

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got valid/fault/result %b/%b/%h, expected %b/%b/%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic op(input logic [10:0] f, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    issue = 1; fid = f; opa = a; opb = b;
    #2 chk(tag, {res_valid, miss_fault, result}, expect_out(f, a, b));
    issue = 0;
  endtask

  task automatic model_wr(input logic [6:0] a, input logic [15:0] d);
    if (a < 7'(NLUT)) begin mdl[a] = d; mvalid = 0; end
    else if (a == 7'h7F) begin mtag = d[10:0]; mvalid = 1; end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
    model_wr(a, d);
  endtask

  task automatic load_random(input logic [10:0] t);
    for (int k = 0; k < NLUT; k++) begin
      wr(7'(k), 16'($urandom));
      // R4: mid-load issue of the new and of the old tag
      if (k % 24 == 5) op(t, $urandom, $urandom, "R4 mid-load");
      if (k % 24 == 11) op(mtag, $urandom, $urandom, "R4 mid-load old tag");
    end
    wr(7'h7F, {5'h0, t});
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] a0, b0, r0;
    void'($urandom(32'd20250515));
    repeat (2) @(negedge clk);
    #2 chk("R7 reset idle", {res_valid, miss_fault, result}, 34'h0);
    rst_n = 1;
    // R3: nothing loaded
    for (int k = 0; k < 12; k++) op(11'($urandom), $urandom, $urandom, "R3 unloaded");
    op(11'h0, 32'hFFFF_FFFF, 32'h0, "R3 unloaded id 0");

    // R1, R2, R6: random configuration
    load_random(11'h5A3);
    for (int k = 0; k < 200; k++) op(11'h5A3, $urandom, $urandom, "R6 random hit");
    for (int k = 0; k < 11; k++) op(11'h5A3 ^ (11'h1 << k), $urandom, $urandom, "R2 one-bit miss");
    for (int k = 0; k < 40; k++) op(($urandom % 2) ? 11'h5A3 : 11'($urandom), $urandom, $urandom, "R1 mixed");

    // R9: interleaved repeat gives the same value
    a0 = $urandom; b0 = $urandom; r0 = model(a0, b0);
    op(11'h5A3, a0, b0, "R9 first");
    for (int k = 0; k < 5; k++) op(11'h5A3, $urandom, $urandom, "R9 between");
    op(11'h5A3, a0, b0, "R9 repeat");
    vecs++;
    if (model(a0, b0) !== r0) begin bad++; $display("FAIL R9: %h vs %h", model(a0, b0), r0); end

    // R8: unmapped addresses ignored
    for (int k = 96; k < 127; k += 10) wr(7'(k), 16'($urandom));
    op(11'h5A3, a0, b0, "R8 after unmapped writes");
    op(11'h5A3, 32'h1234_5678, 32'h9ABC_DEF0, "R8 tables unchanged");

    // R6 directed: result = a ^ b
    for (int k = 0; k < 32; k++) wr(7'(k), 16'h6666);
    for (int k = 32; k < 96; k++) wr(7'(k), 16'hAAAA);
    op(11'h5A3, 32'h0, 32'h0, "R4 tables rewritten, tag stale");
    wr(7'h7F, 16'hF7FF);
    op(11'h7FF, 32'hFFFF_FFFF, 32'h0, "R6 xor all ones");
    op(11'h7FF, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R6 xor equal");
    op(11'h7FF, 32'h8000_0001, 32'h0000_0001, "R6 xor wrap bits");
    op(11'h7FF, 32'h0, 32'h0, "R6 xor zeros");
    op(11'h3FF, 32'h1, 32'h2, "R5 upper data bits not in tag");
    for (int k = 0; k < 30; k++) op(11'h7FF, $urandom, $urandom, "R6 xor random");

    // R10: table write in the same cycle as a hit
    @(negedge clk);
    cfg_we = 1; cfg_addr = 7'd40; cfg_wdata = 16'h0000;
    issue = 1; fid = 11'h7FF; opa = 32'hF0F0_0F0F; opb = 32'h0FF0_0FF0;
    #2 chk("R10 same-cycle write", {res_valid, miss_fault, result}, expect_out(fid, opa, opb));
    @(posedge clk); #1 cfg_we = 0; issue = 0;
    model_wr(7'd40, 16'h0000);
    op(11'h7FF, 32'hF0F0_0F0F, 32'h0FF0_0FF0, "R4 cycle after write");

    // R10: tag write in the same cycle as an issue of the new tag
    @(negedge clk);
    cfg_we = 1; cfg_addr = 7'h7F; cfg_wdata = 16'h0000;
    issue = 1; fid = 11'h000; opa = 32'h3; opb = 32'h5;
    #2 chk("R10 same-cycle tag write", {res_valid, miss_fault, result}, expect_out(fid, opa, opb));
    @(posedge clk); #1 cfg_we = 0; issue = 0;
    model_wr(7'h7F, 16'h0000);
    op(11'h000, 32'h3, 32'h5, "R5 tag 0 live");
    op(11'h7FF, 32'h3, 32'h5, "R2 old tag misses");

    // second random reload
    load_random(11'h24C);
    for (int k = 0; k < 150; k++) op(($urandom % 4 != 0) ? 11'h24C : 11'($urandom), $urandom, $urandom, "R6 reload");

    // R3: reset drops the function
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; mvalid = 0;
    op(11'h24C, 32'h1, 32'h1, "R3 after second reset");
    @(negedge clk);
    #2 chk("R7 idle end", {res_valid, miss_fault, result}, 34'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule